// File: doc/BRIEF.md
# Bisync Character-Mode Serial Transmitter

This block sends bytes as a synchronous, character-oriented serial stream. The host programs it through a small write-only register file, and the line is clocked by a transmit clock supplied from outside the chip. That clock is resynchronised into the system clock domain. Each rising edge of the transmit clock moves one NRZ bit onto `txd`, and every byte goes out least significant bit first. Bytes written to the data address are queued in a four-entry buffer.

Once transmission is enabled, every block opens with a preamble: one pad byte, which is the idle register value, then the first and then the second sync character. The queued bytes follow the preamble. When the queue is empty, the line carries the idle byte over and over. An optional CRC-16 can be appended to each block. The host sees a ready flag, a transmit interrupt and an underrun interrupt, and each interrupt source has its own enable. The `rts` output follows a control bit.

Register addresses on `wr_addr`:
- 0: command
- 1: mode, bit 0 = CRC append
- 2: control, bit 0 = RTS
- 3: ready level
- 4: interrupt enables
- 5: first sync character
- 6: second sync character
- 7: idle/pad byte
- 8: transmit data

Top module: `bsync_tx`

## Requirements
- R1: After reset, `txd`=1, `txrdy`=1, `rts`=0, `ovf_flag`=0, `tx_irq`=0 and `urun_irq`=0.
- R2: While transmission is not enabled, `txd` stays at 1 even when bytes are buffered.
- R3: Writing 0x02 to address 0 enables transmission. From the next transmit-clock rising edge the line sends, one bit per edge and LSB first: the idle byte (address 7), then sync byte 0 (address 5), then sync byte 1 (address 6), then the buffered bytes in write order.
- R4: When no data is queued, the idle byte repeats on the line. A byte queued while idling starts a new block that begins with the idle pad, sync 0 and sync 1.
- R5: An underrun is recorded when the buffer is found empty at a byte boundary while data bytes are being sent. The record is sticky, and `urun_irq` = record AND enable bit 2 of address 4.
- R6: When bit 0 of address 1 is set, a CRC-16 is appended after the last data byte of each block, low byte first. The CRC uses polynomial x^16+x^15+x^2+1 processed LSB first, is preset to 0 at the start of each block, and covers the data bytes only.
- R7: The buffer holds four bytes. A data write while the buffer is full is dropped and never sent, and it sets the sticky `ovf_flag`.
- R8: `txrdy` is 1 exactly when the number of buffered bytes is at most the ready level, which is bits 2:0 of address 3 and is 0 after reset.
- R9: A block-end record is set when the line returns to idle fill after a block. `tx_irq` = (`txrdy` AND bit 0 of address 4) OR (block-end record AND bit 1 of address 4).
- R10: `rts` equals bit 0 of address 2 and is not changed by transmission activity.
- R11: Writing 0x21 to address 0 stops transmission (`txd`=1), empties the buffer, and clears the overflow, underrun and block-end records. Configuration registers keep their values.
- R12: Any other command value written to address 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc | input | 1 | External transmit bit clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial NRZ data, idle high when stopped |
| rts | output | 1 | Request-to-send from control bit |
| txrdy | output | 1 | Buffer at or below ready level |
| tx_irq | output | 1 | Transmit interrupt |
| urun_irq | output | 1 | Underrun interrupt |
| ovf_flag | output | 1 | Sticky buffer overflow |

## Verification
The bench uses the default parameters: a buffer depth of four and two synchroniser stages. With depth four, a fifth write reaches the full-buffer drop. The ready level can be set to 2, which shows `txrdy` changing partway through filling the buffer. A single block with two or four data bytes is short enough to decode the whole preamble, data, CRC and idle-fill sequence. Two blocks are sent back to back in CRC mode to show that the checksum restarts from zero for each block.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [2:0] {
    NX_IDLE,
    NX_SYN0,
    NX_SYN1,
    NX_DATA,
    NX_CRCH,
    NX_END
  } nxt_e;

  localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd2;
  localparam logic [ADDR_W-1:0] A_RLVL = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SYN0 = 4'd5;
  localparam logic [ADDR_W-1:0] A_SYN1 = 4'd6;
  localparam logic [ADDR_W-1:0] A_IDLE = 4'd7;
  localparam logic [ADDR_W-1:0] A_DATA = 4'd8;

  localparam logic [BYTE_W-1:0] CMD_CHRST = 8'h21;
  localparam logic [BYTE_W-1:0] CMD_TXEN  = 8'h02;

  // reflected form of x^16+x^15+x^2+1
  localparam logic [15:0] CRC_POLY_REV = 16'hA001;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/bsync_edge.sv
module bsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc,
  output logic tick
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], txc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // rising edge of the synchronised transmit clock
  assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/bsync_fifo.sv
module bsync_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             ovf_set
);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, wr_ok, rd_ok;
  logic [WIDTH-1:0] rd_vec [DEPTH];

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = push & ~full & ~flush;
  assign rd_ok   = pop & ~empty & ~flush;
  assign ovf_set = push & full & ~flush;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [WIDTH-1:0] ent_q;
      always_ff @(posedge clk) begin
        if (wr_ok && (wptr_q == PTR_W'(g))) ent_q <= wdata;
      end
      assign rd_vec[g] = ent_q;
    end
  endgenerate

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = adv(wptr_q);
      if (rd_ok) rptr_d = adv(rptr_q);
      if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
      else if (!wr_ok && rd_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rdata = rd_vec[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/bsync_crc.sv
module bsync_crc
  import bsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [15:0]       crc
);

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear)    crc_d = '0;
    else if (upd) crc_d = crc_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/bsync_regs.sv
module bsync_regs
  import bsync_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              crc_en,
  output logic              rts,
  output logic [CNT_W-1:0]  rdy_lvl,
  output logic [2:0]        ien,
  output logic [BYTE_W-1:0] syn0,
  output logic [BYTE_W-1:0] syn1,
  output logic [BYTE_W-1:0] idle_pat,
  output logic              cmd_chrst,
  output logic              cmd_txen,
  output logic              push
);

  logic              crc_en_q, crc_en_d, rts_q, rts_d;
  logic [CNT_W-1:0]  lvl_q, lvl_d;
  logic [2:0]        ien_q, ien_d;
  logic [BYTE_W-1:0] syn0_q, syn0_d, syn1_q, syn1_d, idle_q, idle_d;

  always_comb begin
    crc_en_d = crc_en_q;
    rts_d    = rts_q;
    lvl_d    = lvl_q;
    ien_d    = ien_q;
    syn0_d   = syn0_q;
    syn1_d   = syn1_q;
    idle_d   = idle_q;
    if (wr_en) begin
      case (wr_addr)
        A_MODE: crc_en_d = wr_data[0];
        A_CTRL: rts_d    = wr_data[0];
        A_RLVL: lvl_d    = wr_data[CNT_W-1:0];
        A_IEN:  ien_d    = wr_data[2:0];
        A_SYN0: syn0_d   = wr_data;
        A_SYN1: syn1_d   = wr_data;
        A_IDLE: idle_d   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_en_q <= 1'b0;
      rts_q    <= 1'b0;
      lvl_q    <= '0;
      ien_q    <= '0;
      syn0_q   <= '0;
      syn1_q   <= '0;
      idle_q   <= '0;
    end else begin
      crc_en_q <= crc_en_d;
      rts_q    <= rts_d;
      lvl_q    <= lvl_d;
      ien_q    <= ien_d;
      syn0_q   <= syn0_d;
      syn1_q   <= syn1_d;
      idle_q   <= idle_d;
    end
  end

  assign crc_en    = crc_en_q;
  assign rts       = rts_q;
  assign rdy_lvl   = lvl_q;
  assign ien       = ien_q;
  assign syn0      = syn0_q;
  assign syn1      = syn1_q;
  assign idle_pat  = idle_q;
  assign cmd_chrst = wr_en && (wr_addr == A_CMD) && (wr_data == CMD_CHRST);
  assign cmd_txen  = wr_en && (wr_addr == A_CMD) && (wr_data == CMD_TXEN);
  assign push      = wr_en && (wr_addr == A_DATA);

endmodule

// File: rtl/bsync_tx.sv
module bsync_tx
  import bsync_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txc,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              txd,
  output logic              rts,
  output logic              txrdy,
  output logic              tx_irq,
  output logic              urun_irq,
  output logic              ovf_flag
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [1:0]        rsync_q;
  logic              rst_n_s;
  logic              tick;
  logic              crc_en, cmd_chrst, cmd_txen, push;
  logic [CNT_W-1:0]  rdy_lvl, fifo_cnt;
  logic [2:0]        ien;
  logic [BYTE_W-1:0] syn0, syn1, idle_pat, fifo_rdata, ld_byte;
  logic              fifo_empty, ovf_set, pop;
  logic              crc_upd, crc_clr;
  logic [15:0]       crc_val;

  nxt_e              nx_q, nx_d;
  logic              run_q, run_d, fresh_q, fresh_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shr_q, shr_d;
  logic              txd_q, txd_d;
  logic              urun_q, urun_d, done_q, done_d, ovf_q, ovf_d;
  logic              byte_bound;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  bsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .txc(txc), .tick(tick)
  );

  bsync_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .crc_en(crc_en), .rts(rts), .rdy_lvl(rdy_lvl), .ien(ien),
    .syn0(syn0), .syn1(syn1), .idle_pat(idle_pat),
    .cmd_chrst(cmd_chrst), .cmd_txen(cmd_txen), .push(push)
  );

  bsync_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .flush(cmd_chrst), .push(push), .wdata(wr_data),
    .pop(pop), .rdata(fifo_rdata), .count(fifo_cnt), .empty(fifo_empty), .ovf_set(ovf_set)
  );

  bsync_crc u_crc (
    .clk(clk), .rst_n(rst_n_s), .clear(crc_clr), .upd(crc_upd), .din(fifo_rdata), .crc(crc_val)
  );

  assign byte_bound = tick & run_q & (fresh_q | (bcnt_q == BIT_W'(BYTE_W - 1)));

  always_comb begin
    nx_d    = nx_q;
    run_d   = run_q;
    fresh_d = fresh_q;
    bcnt_d  = bcnt_q;
    shr_d   = shr_q;
    txd_d   = txd_q;
    urun_d  = urun_q;
    done_d  = done_q;
    ovf_d   = ovf_q | ovf_set;
    ld_byte = idle_pat;
    pop     = 1'b0;
    crc_upd = 1'b0;
    crc_clr = 1'b0;

    // choose the byte that starts at this boundary
    if (byte_bound) begin
      case (nx_q)
        NX_SYN0: begin ld_byte = syn0; nx_d = NX_SYN1; end
        NX_SYN1: begin ld_byte = syn1; nx_d = NX_DATA; end
        NX_DATA: begin
          if (!fifo_empty) begin
            ld_byte = fifo_rdata;
            pop     = 1'b1;
            crc_upd = 1'b1;
          end else begin
            urun_d = 1'b1;
            if (crc_en) begin
              ld_byte = crc_val[7:0];
              nx_d    = NX_CRCH;
            end else begin
              done_d  = 1'b1;
              crc_clr = 1'b1;
              nx_d    = NX_IDLE;
            end
          end
        end
        NX_CRCH: begin ld_byte = crc_val[15:8]; nx_d = NX_END; end
        NX_END: begin
          done_d  = 1'b1;
          crc_clr = 1'b1;
          nx_d    = fifo_empty ? NX_IDLE : NX_SYN0;
        end
        default: nx_d = fifo_empty ? NX_IDLE : NX_SYN0;
      endcase
    end

    // serialiser, LSB first, one bit per transmit-clock edge
    if (tick && run_q) begin
      if (byte_bound) begin
        txd_d   = ld_byte[0];
        shr_d   = {1'b0, ld_byte[BYTE_W-1:1]};
        bcnt_d  = '0;
        fresh_d = 1'b0;
      end else begin
        txd_d  = shr_q[0];
        shr_d  = {1'b0, shr_q[BYTE_W-1:1]};
        bcnt_d = bcnt_q + 1'b1;
      end
    end else if (!run_q) begin
      txd_d = 1'b1;
    end

    if (cmd_txen && !run_q) begin
      run_d   = 1'b1;
      fresh_d = 1'b1;
      nx_d    = NX_IDLE;
    end

    if (cmd_chrst) begin
      run_d   = 1'b0;
      fresh_d = 1'b0;
      nx_d    = NX_IDLE;
      txd_d   = 1'b1;
      urun_d  = 1'b0;
      done_d  = 1'b0;
      ovf_d   = 1'b0;
      crc_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      nx_q    <= NX_IDLE;
      run_q   <= 1'b0;
      fresh_q <= 1'b0;
      bcnt_q  <= '0;
      shr_q   <= '0;
      txd_q   <= 1'b1;
      urun_q  <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      nx_q    <= nx_d;
      run_q   <= run_d;
      fresh_q <= fresh_d;
      bcnt_q  <= bcnt_d;
      shr_q   <= shr_d;
      txd_q   <= txd_d;
      urun_q  <= urun_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
    end
  end

  assign txd      = txd_q;
  assign txrdy    = (fifo_cnt <= rdy_lvl);
  assign tx_irq   = (txrdy & ien[0]) | (done_q & ien[1]);
  assign urun_irq = urun_q & ien[2];
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/bsync_tx_chk.sv
module bsync_tx_chk
  import bsync_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              run,
  input logic              txd,
  input logic              rts,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              ovf,
  input logic              txrdy,
  input logic              pop,
  input logic              urun
);

  logic rstcmd;
  assign rstcmd = wr_en && (wr_addr == A_CMD) && (wr_data == CMD_CHRST);

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !rstcmd) |=> ovf);

  assert_mark_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> txd);

  assert_bit_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rstcmd) |=> $stable(txd));

  assert_pop_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (tick && run));

  assert_rts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_CTRL)) |=> $stable(rts));

  assert_empty_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == '0) |-> txrdy);

  assert_urun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !rstcmd) |=> urun);

  assert_chrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rstcmd |=> (!run && (fifo_cnt == '0) && !ovf && !urun && txd));

endmodule

bind bsync_tx bsync_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .run(run_q), .txd(txd), .rts(rts), .fifo_cnt(fifo_cnt),
  .ovf(ovf_q), .txrdy(txrdy), .pop(pop), .urun(urun_q)
);

// File: tb/test_bsync_tx.sv
`timescale 1ns/100ps
module test_bsync_tx;

  logic       clk, rst_n, txc, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       txd, rts, txrdy, tx_irq, urun_irq, ovf_flag;

  int   nchk = 0;
  int   nerr = 0;
  bit   finished = 0;
  bit   capt = 0;
  int   ncap = 0;
  logic cap [0:2047];
  logic [7:0] exp_b [0:31];

  bsync_tx i_bsync_tx (
    .clk(clk), .rst_n(rst_n), .txc(txc), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .txd(txd), .rts(rts), .txrdy(txrdy), .tx_irq(tx_irq),
    .urun_irq(urun_irq), .ovf_flag(ovf_flag)
  );

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    txc = 0;
    #1;
    forever #40 txc = ~txc;
  end

  always @(negedge txc) begin
    if (capt) begin
      cap[ncap] = txd;
      ncap++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [7:0] got_byte(input int k);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = cap[8*k + i];
    return b;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic start_tx();
    @(negedge txc);
    #2;
    wr(4'd0, 8'h02);
    ncap = 0;
    capt = 1;
  endtask

  task automatic chan_reset();
    wr(4'd0, 8'h21);
    capt = 0;
  endtask

  task automatic wait_bytes(input int n);
    wait (ncap >= 8*n);
  endtask

  task automatic chk_bytes(input string tag, input int first, input int n);
    for (int k = first; k < first + n; k++) chk(tag, got_byte(k), exp_b[k]);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // R1: reset values at the ports
  task automatic t_reset();
    chk("R1 txd", txd, 1);
    chk("R1 txrdy", txrdy, 1);
    chk("R1 rts", rts, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 urun_irq", urun_irq, 0);
  endtask

  // R2, R12, R11: data buffered but not enabled; unknown command ignored
  task automatic t_disabled();
    wr(4'd8, 8'h5A);
    chk("R8 txrdy after write", txrdy, 0);
    wr(4'd0, 8'h55);
    for (int i = 0; i < 6; i++) begin
      @(negedge txc);
      chk("R2 R12 txd held", txd, 1);
    end
    chk("R12 buffer kept", txrdy, 0);
    chan_reset();
    chk("R11 buffer flushed", txrdy, 1);
  endtask

  // R3, R4, R5, R9, R10: one block, idle fill, then a second block
  task automatic t_basic();
    wr(4'd5, 8'h16);
    wr(4'd6, 8'h96);
    wr(4'd7, 8'h3C);
    wr(4'd4, 8'h02);
    wr(4'd2, 8'h01);
    chk("R10 rts set", rts, 1);
    wr(4'd8, 8'hA1);
    wr(4'd8, 8'hB2);
    wr(4'd8, 8'hC3);
    start_tx();
    wait_bytes(8);
    wr(4'd8, 8'hD4);
    exp_b[0] = 8'h3C; exp_b[1] = 8'h16; exp_b[2] = 8'h96; exp_b[3] = 8'hA1;
    exp_b[4] = 8'hB2; exp_b[5] = 8'hC3; exp_b[6] = 8'h3C; exp_b[7] = 8'h3C;
    chk_bytes("R3 R4 block one", 0, 8);
    wait_bytes(13);
    exp_b[8] = 8'h3C; exp_b[9] = 8'h16; exp_b[10] = 8'h96; exp_b[11] = 8'hD4;
    exp_b[12] = 8'h3C;
    chk_bytes("R4 new block preamble", 8, 5);
    chk("R9 block end irq", tx_irq, 1);
    chk("R5 urun gated", urun_irq, 0);
    wr(4'd4, 8'h06);
    chk("R5 urun sticky irq", urun_irq, 1);
    chk("R10 rts unchanged", rts, 1);
    chan_reset();
  endtask

  // R6: two CRC blocks, each preset to zero
  task automatic t_crc();
    logic [15:0] c1, c2;
    wr(4'd4, 8'h00);
    wr(4'd1, 8'h01);
    wr(4'd8, 8'h31);
    wr(4'd8, 8'h32);
    c1 = ref_crc(ref_crc(16'h0000, 8'h31), 8'h32);
    c2 = ref_crc(ref_crc(16'h0000, 8'h33), 8'h34);
    start_tx();
    wait_bytes(9);
    wr(4'd8, 8'h33);
    wr(4'd8, 8'h34);
    wait_bytes(17);
    exp_b[0] = 8'h3C; exp_b[1] = 8'h16; exp_b[2] = 8'h96; exp_b[3] = 8'h31;
    exp_b[4] = 8'h32; exp_b[5] = c1[7:0]; exp_b[6] = c1[15:8]; exp_b[7] = 8'h3C;
    exp_b[8] = 8'h3C; exp_b[9] = 8'h3C; exp_b[10] = 8'h16; exp_b[11] = 8'h96;
    exp_b[12] = 8'h33; exp_b[13] = 8'h34; exp_b[14] = c2[7:0]; exp_b[15] = c2[15:8];
    exp_b[16] = 8'h3C;
    chk_bytes("R6 crc blocks", 0, 17);
    chan_reset();
    wr(4'd1, 8'h00);
  endtask

  // R7, R8, R9, R11: ready level, overflow drop, reset clearing
  task automatic t_ovf_lvl();
    wr(4'd3, 8'h02);
    wr(4'd8, 8'h11);
    wr(4'd8, 8'h22);
    chk("R8 at level", txrdy, 1);
    wr(4'd8, 8'h33);
    chk("R8 above level", txrdy, 0);
    wr(4'd8, 8'h44);
    chk("R7 no ovf at full", ovf_flag, 0);
    wr(4'd8, 8'hEE);
    chk("R7 ovf set", ovf_flag, 1);
    wr(4'd4, 8'h01);
    chk("R9 rdy irq low", tx_irq, 0);
    start_tx();
    wait_bytes(9);
    exp_b[0] = 8'h3C; exp_b[1] = 8'h16; exp_b[2] = 8'h96; exp_b[3] = 8'h11;
    exp_b[4] = 8'h22; exp_b[5] = 8'h33; exp_b[6] = 8'h44; exp_b[7] = 8'h3C;
    exp_b[8] = 8'h3C;
    chk_bytes("R7 dropped byte not sent", 0, 9);
    chk("R7 ovf sticky", ovf_flag, 1);
    chk("R9 rdy irq high", tx_irq, 1);
    wr(4'd4, 8'h04);
    chk("R5 urun after block", urun_irq, 1);
    chan_reset();
    chk("R11 ovf cleared", ovf_flag, 0);
    chk("R11 urun cleared", urun_irq, 0);
    chk("R11 txd mark", txd, 1);
    chk("R11 rts kept", rts, 1);
    @(negedge txc);
    @(negedge txc);
    chk("R11 stopped", txd, 1);
  endtask

  initial begin
    #(5 * 150000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    wr_en = 0; wr_addr = '0; wr_data = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_crc();
    t_ovf_lvl();
    finish_run();
  end

endmodule